// File: doc/BRIEF.md
# Latched Fault Alert Controller

This block drives an active-low alert line toward a management host. It watches a vector of fault and state conditions: input voltage, output voltage, overcurrent, temperature, fan, communication, packet-check error, invalid command, out-of-range data and internal fault. Any movement of any condition, whether it rises or falls, pulls the alert low. The line then stays low until the host does one of four things: it finishes a status read, it issues a clear-faults command, or it switches the main output off and back on again. That off-then-on can come either from the enable pin or from the operation command.

Clearing depends on the conditions at that moment. If every condition is quiet when a clear event arrives, the alert is released and stays high. If any condition is still active, the alert is released for one cycle and then pulled low again. It then stays latched until the next clear. Beside the alert, a sticky status vector records which conditions have been active since the last clear. A clear reloads the vector with the conditions that are active at that moment.

Top module: `falert_ctrl`

## Requirements
- R1: After synchronous reset, `alert_n_o` is 1 and `status_o` is all zeros.
- R2: A condition bit going from 0 to 1 drives `alert_n_o` to 0 from the clock edge that samples it.
- R3: A condition bit going from 1 to 0 also drives `alert_n_o` to 0, including in the one-cycle release window that follows a clear.
- R4: Once low, `alert_n_o` stays low while no clear event occurs, even after every condition has returned to 0.
- R5: A one-cycle pulse on `rd_status_done_i`, with no condition active and none changing, returns `alert_n_o` to 1 at that edge.
- R6: A one-cycle pulse on `clr_faults_cmd_i`, under the same quiet conditions, returns `alert_n_o` to 1 at that edge.
- R7: `pin_en_i` sampled at 0 and then at 1 on the next sampled edge counts as a clear event at the edge that samples the 1. The 0 level alone has no effect on the alert.
- R8: `op_en_i` going from 0 to 1 counts as a clear event in the same way as in R7. The 0 level alone has no effect on the alert.
- R9: A clear event while any condition is still active sets `alert_n_o` to 1 for exactly one cycle. If a condition is still active on the following edge, the alert returns to 0 and latches again.
- R10: `status_o` bit i is set whenever `cond_i` bit i is sampled as 1, and it stays set after that condition drops. On a clear event, `status_o` is loaded with the current `cond_i`. The bit positions are: 0 input voltage, 1 output voltage, 2 overcurrent, 3 temperature, 4 fan, 5 communication, 6 packet-check error, 7 invalid command, 8 out-of-range data, 9 internal fault.
- R11: A condition change sampled in the same cycle as a clear event keeps `alert_n_o` at 0, so the change takes priority over the clear.
- R12: A clear event while the alert is high and no condition changes leaves `alert_n_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cond_i | input | N_COND (10) | Condition levels, using the bit positions listed in R10 |
| rd_status_done_i | input | 1 | Pulse when a status read has completed |
| clr_faults_cmd_i | input | 1 | Pulse when a clear-faults command is received |
| pin_en_i | input | 1 | Main output enable level from the enable pin |
| op_en_i | input | 1 | Main output enable level from the operation command |
| alert_n_o | output | 1 | Active-low alert level |
| status_o | output | N_COND (10) | Sticky condition record |

## Verification
The assertions check on every cycle that a sampled change always leads to the latched state. They also check that a latched alert cannot leave that state without a clear event, and that a clear with a condition still active passes through the release window instead of going idle. Further properties cover the sticky status, which never drops a bit without a clear, and the recycle pulse, which never lasts longer than one cycle. Only the bench scenarios can show the visible ordering: the one-cycle high pulse after a clear that cannot succeed, the priority of a change over a simultaneous clear, and whether each recycle path needs both its off phase and its on phase.

// File: rtl/falert_pkg.sv
package falert_pkg;

    localparam int unsigned N_COND_DEF = 10;
    localparam int unsigned N_EN_SRC   = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LATCHED = 2'd1,
        ST_REARM   = 2'd2
    } alert_st_e;

    typedef struct packed {
        logic changed;
        logic clear;
        logic active;
    } alert_evt_t;

    function automatic alert_st_e next_state(alert_st_e cur, alert_evt_t ev);
        alert_st_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE: begin
                if (ev.changed) nxt = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (ev.changed)     nxt = ST_LATCHED;
                else if (ev.clear)  nxt = ev.active ? ST_REARM : ST_IDLE;
            end
            ST_REARM: begin
                if (ev.changed || ev.active) nxt = ST_LATCHED;
                else                         nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/falert_change_det.sv
module falert_change_det #(
    parameter int unsigned W = 10
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] cond_i,
    output logic         changed_o,
    output logic         active_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= cond_i;
    end

    assign changed_o = |(cond_i ^ prev_q);
    assign active_o  = |cond_i;

endmodule

// File: rtl/falert_recycle_det.sv
module falert_recycle_det #(
    parameter int unsigned N_SRC = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_SRC-1:0] en_i,
    output logic [N_SRC-1:0] recycle_o
);
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            logic en_prev_q;

            always_ff @(posedge clk_i) begin
                if (rst_i) en_prev_q <= 1'b1;
                else       en_prev_q <= en_i[g];
            end

            assign recycle_o[g] = en_i[g] & ~en_prev_q;

            p_recycle_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
                recycle_o[g] |=> !recycle_o[g]);
        end
    endgenerate

endmodule

// File: rtl/falert_status.sv
module falert_status #(
    parameter int unsigned W = 10
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clear_i,
    input  logic [W-1:0] cond_i,
    output logic [W-1:0] status_o
);
    logic [W-1:0] status_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        status_q <= '0;
        else if (clear_i) status_q <= cond_i;
        else              status_q <= status_q | cond_i;
    end

    assign status_o = status_q;

    p_sticky_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !clear_i |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: rtl/falert_fsm.sv
module falert_fsm
    import falert_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  alert_evt_t evt_i,
    output alert_st_e  state_o
);
    alert_st_e state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= next_state(state_q, evt_i);
    end

    assign state_o = state_q;

    p_change_latches_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i.changed |=> state_q == ST_LATCHED);

    p_hold_latched_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LATCHED && !evt_i.clear) |=> state_q == ST_LATCHED);

    p_rearm_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LATCHED && evt_i.clear && !evt_i.changed && evt_i.active)
        |=> state_q == ST_REARM);

    p_release_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LATCHED && evt_i.clear && !evt_i.changed && !evt_i.active)
        |=> state_q == ST_IDLE);

endmodule

// File: rtl/falert_ctrl.sv
module falert_ctrl
    import falert_pkg::*;
#(
    parameter int unsigned N_COND = N_COND_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [N_COND-1:0] cond_i,
    input  logic              rd_status_done_i,
    input  logic              clr_faults_cmd_i,
    input  logic              pin_en_i,
    input  logic              op_en_i,
    output logic              alert_n_o,
    output logic [N_COND-1:0] status_o
);
    logic                changed;
    logic                active;
    logic [N_EN_SRC-1:0] recycle;
    logic                clear_evt;
    alert_evt_t          evt;
    alert_st_e           state;

    falert_change_det #(.W(N_COND)) u_chg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cond_i    (cond_i),
        .changed_o (changed),
        .active_o  (active)
    );

    falert_recycle_det #(.N_SRC(N_EN_SRC)) u_rcy (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      ({op_en_i, pin_en_i}),
        .recycle_o (recycle)
    );

    assign clear_evt = rd_status_done_i | clr_faults_cmd_i | (|recycle);

    always_comb begin
        evt         = '0;
        evt.changed = changed;
        evt.clear   = clear_evt;
        evt.active  = active;
    end

    falert_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .evt_i   (evt),
        .state_o (state)
    );

    falert_status #(.W(N_COND)) u_sts (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clear_i  (clear_evt),
        .cond_i   (cond_i),
        .status_o (status_o)
    );

    assign alert_n_o = (state != ST_LATCHED);

    p_idle_clear_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_IDLE && !changed) |=> alert_n_o);

    p_change_wins_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (changed && clear_evt) |=> !alert_n_o);

endmodule

// File: tb/falert_ctrl_tb_top.sv
module falert_ctrl_tb_top;

    localparam int NC = 10;
    localparam int NV = 28;

    logic          clk = 1'b0;
    logic          rst;
    logic [NC-1:0] cond;
    logic          rd, clr, pin, op;
    logic          alert_n;
    logic [NC-1:0] status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    falert_ctrl #(.N_COND(NC)) dut_i (
        .clk_i            (clk),
        .rst_i            (rst),
        .cond_i           (cond),
        .rd_status_done_i (rd),
        .clr_faults_cmd_i (clr),
        .pin_en_i         (pin),
        .op_en_i          (op),
        .alert_n_o        (alert_n),
        .status_o         (status)
    );

    typedef struct packed {
        logic [NC-1:0] cond;
        logic          rd;
        logic          clr;
        logic          pin;
        logic          op;
        logic          exp_n;
        logic [NC-1:0] exp_st;
        logic [7:0]    req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 8'd1},  // R1 idle
        '{10'h001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h001, 8'd2},  // R2 rise
        '{10'h001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h001, 8'd4},  // R4
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h001, 8'd4},  // R4 R10 sticky
        '{10'h000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 8'd5},  // R5 status read
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 8'd5},  // R5
        '{10'h080, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h080, 8'd2},  // R2 invalid cmd
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h080, 8'd4},  // R4
        '{10'h000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 8'd6},  // R6 clear faults
        '{10'h004, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h004, 8'd2},  // R2
        '{10'h004, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h004, 8'd9},  // R9 release window
        '{10'h004, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h004, 8'd9},  // R9 relatch
        '{10'h004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'h004, 8'd9},  // R9 via read
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h004, 8'd3},  // R3 fall
        '{10'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'h004, 8'd7},  // R7 off only
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 8'd7},  // R7 on again
        '{10'h200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h200, 8'd2},  // R2 internal
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h200, 8'd4},  // R4
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'h200, 8'd8},  // R8 off only
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 8'd8},  // R8 on again
        '{10'h000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 8'd12}, // R12
        '{10'h002, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'h002, 8'd11}, // R11
        '{10'h002, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h002, 8'd4},  // R4
        '{10'h042, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h042, 8'd10}, // R10 accumulate
        '{10'h040, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'h040, 8'd11}, // R11 fall + read
        '{10'h040, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h040, 8'd9},  // R9
        '{10'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'h040, 8'd3},  // R3 fall in window
        '{10'h000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 8'd6}   // R6
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_n(input logic exp, input int req, input string tag);
        checks++;
        if (alert_n !== exp) begin
            errors++;
            $display("FAIL R%0d %s: alert_n actual=%b expected=%b", req, tag, alert_n, exp);
        end
    endtask

    task automatic chk_st(input logic [NC-1:0] exp, input int req, input string tag);
        checks++;
        if (status !== exp) begin
            errors++;
            $display("FAIL R%0d %s: status actual=%h expected=%h", req, tag, status, exp);
        end
    endtask

    initial begin
        rst = 1'b1; cond = '0; rd = 1'b0; clr = 1'b0; pin = 1'b1; op = 1'b1;
        step(); step();
        // R1 reset state
        chk_n(1'b1, 1, "reset");
        chk_st('0, 1, "reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            cond = VECS[i].cond; rd = VECS[i].rd; clr = VECS[i].clr;
            pin  = VECS[i].pin;  op = VECS[i].op;
            step();
            chk_n(VECS[i].exp_n, int'(VECS[i].req), $sformatf("vec%0d", i));
            chk_st(VECS[i].exp_st, int'(VECS[i].req), $sformatf("vec%0d", i));
        end
        rd = 1'b0; clr = 1'b0;

        // R10 all conditions at once
        cond = '1;
        step();
        chk_n(1'b0, 10, "all bits");
        chk_st('1, 10, "all bits");

        // R1 reset while latched
        cond = '0;
        rst  = 1'b1;
        step();
        chk_n(1'b1, 1, "mid reset");
        chk_st('0, 1, "mid reset");
        rst = 1'b0;
        step();
        chk_n(1'b1, 1, "after reset");

        // R7 pin held low for several cycles, no release until it returns
        cond = 10'h010;
        step();
        cond = '0;
        pin  = 1'b0;
        step(); step(); step();
        chk_n(1'b0, 7, "pin low hold");
        pin = 1'b1;
        step();
        chk_n(1'b1, 7, "pin back high");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule